// File: doc/BRIEF.md
# Spectral Tuple Huffman Packer

This block turns a stream of signed quantized spectral coefficients into variable-length code fields. Each incoming coefficient carries a codebook selection. The selected codebook fixes two things: whether coefficients are grouped in twos or in fours, and the largest magnitude the book can represent. Once a group is complete, the block forms a table index from the group's magnitudes and reads a codeword from a small placeholder codeword store. It then emits that codeword, followed by one sign bit for each nonzero coefficient, as a left-aligned field together with its bit length.

Coefficients enter on a valid/ready stream, lowest frequency first. An optional group-end marker closes a group early, for example at the edge of a band. Fields leave on a second valid/ready stream. When the output is held off, the block stops accepting coefficients. A magnitude that exceeds the selected book's limit is clamped to that limit, and a sticky error flag is raised.

Top module: `huff_tuple_packer`

## Requirements
- R1: After reset, `out_valid` and `range_err` are 0, and `in_ready` is 1 whenever `out_ready` is 1.
- R2: Book values 0..11 form six pairs, one pair per value of book/2. Pairs 0..5 have group sizes 4,4,2,2,2,2, maximum magnitudes 1,2,4,7,12,16, and codeword widths W of 4,7,5,6,8,9 bits.
- R3: The table index is a mixed-radix number with radix (max+1). The first accepted coefficient of a group is its most significant digit, and each digit is the coefficient's clamped magnitude.
- R4: For an even book the codeword is the index written in W bits. For an odd book it is the bitwise complement of the index within W bits. The codeword occupies the top W bits of the 24-bit `out_field`.
- R5: Directly after the codeword comes one sign bit per nonzero coefficient, in arrival order; the bit is 1 for a negative coefficient. Zero coefficients add no bit. `out_len` equals W plus the number of nonzero coefficients, and every bit of `out_field` below that length is 0.
- R6: A group closes when its size is reached, or earlier when `in_end` is 1 on an accepted coefficient. In an early-closed group the missing positions count as zero.
- R7: A coefficient whose magnitude exceeds the book maximum is coded at that maximum and sets `range_err`. `range_err` stays at 1 until reset and never rises without such a coefficient.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_field` and `out_len` hold steady and `in_ready` is 0.
- R9: Exactly one field is emitted per group, in the cycle after its last coefficient is accepted. The book is taken from the first coefficient of the group, and book values on later coefficients of the same group are ignored.
- R10: Book values 12..15 behave as book 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient valid |
| in_ready | output | 1 | Coefficient accepted when high with in_valid |
| in_coef | input | 8 | Two's complement coefficient |
| in_book | input | 4 | Codebook selection |
| in_end | input | 1 | Closes the current group early |
| out_valid | output | 1 | Field valid |
| out_ready | input | 1 | Field consumer ready |
| out_field | output | 24 | Left-aligned codeword and sign bits |
| out_len | output | 5 | Number of meaningful bits in out_field |
| range_err | output | 1 | Sticky magnitude overflow flag |

## Verification
The hardest case to reach is a stall that lands exactly on the cycle in which a group's last coefficient is offered. When that happens, the pending field must stay frozen while the closing coefficient waits, and the waiting coefficient must not slip into the old group's bookkeeping. The stimulus reaches this case by switching the consumer to an irregular ready pattern while a long run of groups across all books streams in back to back. This makes held fields coincide with group closures many times. Separate groups change the book value in mid-group, or close early with the end marker, so that the book latch and the zero fill are exercised apart from the main path.

// File: rtl/hufpk_pkg.sv
package hufpk_pkg;
  localparam int BOOKS = 12;
  localparam int MAX_TUPLE = 4;

  function automatic int bk_tuple(input int b);
    int r;
    r = (b < 4) ? 4 : 2;
    return r;
  endfunction

  function automatic int bk_max(input int b);
    int r;
    case (b / 2)
      0: r = 1;
      1: r = 2;
      2: r = 4;
      3: r = 7;
      4: r = 12;
      default: r = 16;
    endcase
    return r;
  endfunction

  function automatic int bk_width(input int b);
    int r;
    case (b / 2)
      0: r = 4;
      1: r = 7;
      2: r = 5;
      3: r = 6;
      4: r = 8;
      default: r = 9;
    endcase
    return r;
  endfunction

  function automatic int bk_entries(input int b);
    int e;
    e = 1;
    for (int k = 0; k < bk_tuple(b); k++) e = e * (bk_max(b) + 1);
    return e;
  endfunction

  function automatic int bk_base(input int b);
    int s;
    s = 0;
    for (int j = 0; j < b; j++) s = s + bk_entries(j);
    return s;
  endfunction

  localparam int ROM_DEPTH = bk_base(BOOKS);
endpackage

// File: rtl/hp_coef_conform.sv
module hp_coef_conform #(
  parameter int COEF_W = 8,
  parameter int MAG_W  = 5
) (
  input  logic [COEF_W-1:0] coef_i,
  input  logic [MAG_W-1:0]  max_i,
  output logic [MAG_W-1:0]  mag_o,
  output logic              neg_o,
  output logic              nz_o,
  output logic              over_o
);
  logic [COEF_W-1:0] absv;
  logic [COEF_W-1:0] max_ext;

  assign absv    = coef_i[COEF_W-1] ? (~coef_i + 1'b1) : coef_i;
  assign max_ext = {{(COEF_W-MAG_W){1'b0}}, max_i};
  assign over_o  = absv > max_ext;
  assign mag_o   = over_o ? max_i : absv[MAG_W-1:0];
  assign neg_o   = coef_i[COEF_W-1];
  assign nz_o    = |coef_i;
endmodule

// File: rtl/hp_cw_rom.sv
module hp_cw_rom #(
  parameter int CW_W   = 16,
  parameter int DEPTH  = hufpk_pkg::ROM_DEPTH,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CW_W-1:0]   cw_o
);
  import hufpk_pkg::*;

  logic [CW_W-1:0] mem [DEPTH];

  initial begin
    for (int b = 0; b < BOOKS; b++) begin
      for (int i = 0; i < bk_entries(b); i++) begin
        int v;
        v = ((b % 2) == 1) ? ((~i) & ((1 << bk_width(b)) - 1)) : i;
        mem[bk_base(b) + i] = CW_W'(v);
      end
    end
  end

  assign cw_o = mem[addr_i];
endmodule

// File: rtl/hp_field_pack.sv
module hp_field_pack #(
  parameter int FIELD_W = 24,
  parameter int CW_W    = 16,
  parameter int LEN_W   = 5,
  parameter int TUP     = 4
) (
  input  logic [CW_W-1:0]    cw_i,
  input  logic [LEN_W-1:0]   cw_len_i,
  input  logic [TUP-1:0]     nz_i,
  input  logic [TUP-1:0]     neg_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [LEN_W-1:0]   len_o
);
  localparam int FI_W = $clog2(FIELD_W);

  always_comb begin
    int bp;
    int cnt;
    field_o = {cw_i, {(FIELD_W-CW_W){1'b0}}} << (CW_W - int'(cw_len_i));
    bp  = FIELD_W - int'(cw_len_i);
    cnt = 0;
    for (int k = 0; k < TUP; k++) begin
      if (nz_i[k]) begin
        field_o[FI_W'(bp - 1 - cnt)] = neg_i[k];
        cnt = cnt + 1;
      end
    end
    len_o = cw_len_i + LEN_W'(cnt);
  end
endmodule

// File: rtl/huff_tuple_packer.sv
module huff_tuple_packer #(
  parameter int COEF_W  = 8,
  parameter int BOOK_W  = 4,
  parameter int CW_W    = 16,
  parameter int FIELD_W = 24,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COEF_W-1:0]  in_coef,
  input  logic [BOOK_W-1:0]  in_book,
  input  logic               in_end,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FIELD_W-1:0] out_field,
  output logic [LEN_W-1:0]   out_len,
  output logic               range_err
);
  import hufpk_pkg::*;

  localparam int TUP    = MAX_TUPLE;
  localparam int MAG_W  = 5;
  localparam int POS_W  = $clog2(TUP);
  localparam int ADDR_W = $clog2(ROM_DEPTH);
  localparam logic [BOOK_W-1:0] LAST_BOOK = BOOK_W'(BOOKS - 1);

  logic [POS_W-1:0]  pos_q;
  logic [BOOK_W-1:0] book_q;
  logic [MAG_W-1:0]  mag_q [TUP];
  logic [TUP-1:0]    nz_q;
  logic [TUP-1:0]    neg_q;

  logic [BOOK_W-1:0] book_raw, book_sel;
  int                tsize, maxm, cwlen, base, idx;
  logic [MAG_W-1:0]  cur_mag;
  logic              cur_neg, cur_nz, cur_over;
  logic [MAG_W-1:0]  slot_mag [TUP];
  logic [TUP-1:0]    slot_nz, slot_neg;
  logic [ADDR_W-1:0] rom_addr;
  logic [CW_W-1:0]   rom_cw;
  logic [FIELD_W-1:0] new_field;
  logic [LEN_W-1:0]   new_len;
  logic              fire, last;

  // book latched at the first coefficient of a group
  assign book_raw = (pos_q == '0) ? in_book : book_q;
  assign book_sel = (book_raw > LAST_BOOK) ? LAST_BOOK : book_raw;

  always_comb begin
    tsize = bk_tuple(int'(book_sel));
    maxm  = bk_max(int'(book_sel));
    cwlen = bk_width(int'(book_sel));
    base  = bk_base(int'(book_sel));
  end

  hp_coef_conform #(.COEF_W(COEF_W), .MAG_W(MAG_W)) u_conform (
    .coef_i (in_coef),
    .max_i  (MAG_W'(maxm)),
    .mag_o  (cur_mag),
    .neg_o  (cur_neg),
    .nz_o   (cur_nz),
    .over_o (cur_over)
  );

  for (genvar k = 0; k < TUP; k++) begin : g_slot
    always_comb begin
      if (POS_W'(k) < pos_q) begin
        slot_mag[k] = mag_q[k];
        slot_nz[k]  = nz_q[k];
        slot_neg[k] = neg_q[k];
      end else if (POS_W'(k) == pos_q) begin
        slot_mag[k] = cur_mag;
        slot_nz[k]  = cur_nz;
        slot_neg[k] = cur_neg;
      end else begin
        slot_mag[k] = '0;
        slot_nz[k]  = 1'b0;
        slot_neg[k] = 1'b0;
      end
    end
  end

  always_comb begin
    idx = 0;
    for (int k = 0; k < TUP; k++) begin
      if (k < tsize) idx = idx * (maxm + 1) + int'(slot_mag[k]);
    end
    rom_addr = ADDR_W'(base + idx);
  end

  hp_cw_rom #(.CW_W(CW_W), .DEPTH(ROM_DEPTH), .ADDR_W(ADDR_W)) u_rom (
    .addr_i (rom_addr),
    .cw_o   (rom_cw)
  );

  hp_field_pack #(.FIELD_W(FIELD_W), .CW_W(CW_W), .LEN_W(LEN_W), .TUP(TUP)) u_pack (
    .cw_i     (rom_cw),
    .cw_len_i (LEN_W'(cwlen)),
    .nz_i     (slot_nz),
    .neg_i    (slot_neg),
    .field_o  (new_field),
    .len_o    (new_len)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign last     = fire && (in_end || (int'(pos_q) == tsize - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      book_q    <= '0;
      nz_q      <= '0;
      neg_q     <= '0;
      out_valid <= 1'b0;
      out_field <= '0;
      out_len   <= '0;
      range_err <= 1'b0;
      for (int k = 0; k < TUP; k++) mag_q[k] <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fire) begin
        if (cur_over) range_err <= 1'b1;
        if (pos_q == '0) book_q <= book_sel;
        if (last) begin
          pos_q     <= '0;
          out_valid <= 1'b1;
          out_field <= new_field;
          out_len   <= new_len;
        end else begin
          pos_q        <= pos_q + 1'b1;
          mag_q[pos_q] <= cur_mag;
          nz_q[pos_q]  <= cur_nz;
          neg_q[pos_q] <= cur_neg;
        end
      end
    end
  end
endmodule

// File: rtl/hp_checks.sv
module hp_checks #(
  parameter int FIELD_W = 24,
  parameter int LEN_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [FIELD_W-1:0] out_field,
  input logic [LEN_W-1:0]   out_len,
  input logic               range_err
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_field) && $stable(out_len));

  assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    range_err |=> range_err);

  assert_len_span_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= LEN_W'(4)) && (out_len <= LEN_W'(20)));

  assert_tail_zero_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_field << out_len) == '0));
endmodule

bind huff_tuple_packer hp_checks #(.FIELD_W(FIELD_W), .LEN_W(LEN_W)) u_checks (.*);

// File: tb/huff_tuple_packer_tb_top.sv
module huff_tuple_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_coef = '0;
  logic [3:0]  in_book = '0;
  logic        in_end = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_field;
  logic [4:0]  out_len;
  logic        range_err;

  int total = 0;
  int bad = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;

  logic [28:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  huff_tuple_packer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_book(in_book), .in_end(in_end),
    .out_valid(out_valid), .out_ready(out_ready), .out_field(out_field),
    .out_len(out_len), .range_err(range_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent model of the book table and field layout
  task automatic expect_tuple(input int book, input int c0, input int c1, input int c2,
                              input int c3, input int n, input string tag);
    int b, ts, mx, w, idx, nz, bp, cw, m;
    int cs [4];
    logic [23:0] f;
    b = (book > 11) ? 11 : book;
    case (b / 2)
      0: begin ts = 4; mx = 1;  w = 4; end
      1: begin ts = 4; mx = 2;  w = 7; end
      2: begin ts = 2; mx = 4;  w = 5; end
      3: begin ts = 2; mx = 7;  w = 6; end
      4: begin ts = 2; mx = 12; w = 8; end
      default: begin ts = 2; mx = 16; w = 9; end
    endcase
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
    for (int k = 0; k < 4; k++) if (k >= n) cs[k] = 0;
    idx = 0; nz = 0;
    for (int k = 0; k < ts; k++) begin
      m = (cs[k] < 0) ? -cs[k] : cs[k];
      if (m > mx) m = mx;
      idx = idx * (mx + 1) + m;
    end
    cw = ((b % 2) == 1) ? ((~idx) & ((1 << w) - 1)) : idx;
    f = 24'(cw) << (24 - w);
    bp = 24 - w;
    for (int k = 0; k < ts; k++) begin
      if (cs[k] != 0) begin
        bp--;
        nz++;
        f[bp] = (cs[k] < 0);
      end
    end
    exp_q.push_back({f, 5'(w + nz)});
    tag_q.push_back(tag);
  endtask

  task automatic drive_coef(input int c, input int book, input bit endf);
    bit acc;
    in_valid = 1'b1;
    in_coef  = 8'(c);
    in_book  = 4'(book);
    in_end   = endf;
    forever begin
      acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  // n coefficients; early closes with the end marker on the last one
  task automatic send_tuple(input int book, input int alt_book, input int c0, input int c1,
                            input int c2, input int c3, input int n, input bit early,
                            input string tag);
    int cs [4];
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
    expect_tuple(book, c0, c1, c2, c3, n, tag);
    for (int k = 0; k < n; k++)
      drive_coef(cs[k], (k == 0) ? book : alt_book, early && (k == n - 1));
  endtask

  function automatic int tsz(input int book);
    return (book < 4) ? 4 : 2;
  endfunction

  function automatic int mxm(input int book);
    int r;
    case (book / 2)
      0: r = 1; 1: r = 2; 2: r = 4; 3: r = 7; 4: r = 12; default: r = 16;
    endcase
    return r;
  endfunction

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // consumer ready, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      out_ready = (rst || !bp_mode) ? 1'b1 : (($urandom % 3) != 0);
    end
  end

  // monitor / scoreboard
  logic        held = 1'b0;
  logic [28:0] held_val = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (held) check(out_valid && ({out_field, out_len} == held_val), "R8 held field",
                      {3'b0, out_field, out_len}, {3'b0, held_val});
      if (out_valid && !out_ready) begin
        check(!in_ready, "R8 in_ready during stall", {31'b0, in_ready}, 32'd0);
        held = 1'b1;
        held_val = {out_field, out_len};
      end else begin
        held = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected field", {3'b0, out_field, out_len}, 32'd0);
        end else begin
          logic [28:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_field, out_len} == e, t, {3'b0, out_field, out_len}, {3'b0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", {31'b0, out_valid}, 32'd0);
    check(range_err == 1'b0, "R1 range_err", {31'b0, range_err}, 32'd0);
    check(in_ready == 1'b1, "R1 in_ready", {31'b0, in_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);

    // R3: digit order
    send_tuple(4, 4, 3, 0, 0, 0, 2, 1'b0, "R3 first digit high");
    send_tuple(4, 4, 0, 3, 0, 0, 2, 1'b0, "R3 second digit low");
    send_tuple(0, 0, 1, 0, 0, 1, 4, 1'b0, "R3 four digit order");
    // R4: even and odd books
    send_tuple(6, 6, 5, 2, 0, 0, 2, 1'b0, "R4 even book");
    send_tuple(7, 7, 5, 2, 0, 0, 2, 1'b0, "R4 odd book complement");
    // R5: signs
    send_tuple(0, 0, -1, 1, -1, 0, 4, 1'b0, "R5 sign bits");
    send_tuple(2, 2, 0, 0, 0, 0, 4, 1'b0, "R5 all zero no signs");
    send_tuple(3, 3, -2, -2, -2, -2, 4, 1'b0, "R5 four negatives");
    // R2: every book
    for (int b = 0; b < 12; b++) begin
      for (int j = 0; j < 3; j++) begin
        int mx, v [4];
        mx = mxm(b);
        for (int k = 0; k < 4; k++) v[k] = ((k * 5 + b * 3 + j * 7) % (2 * mx + 1)) - mx;
        send_tuple(b, b, v[0], v[1], v[2], v[3], tsz(b), 1'b0, "R2 book table");
      end
    end
    // R6: early close
    send_tuple(0, 0, -1, 1, 0, 0, 2, 1'b1, "R6 early close size four");
    send_tuple(10, 10, -9, 0, 0, 0, 1, 1'b1, "R6 early close size two");
    send_tuple(1, 1, 1, 1, 1, 0, 3, 1'b1, "R6 early close odd book");
    // R9: book changes mid group are ignored
    send_tuple(0, 4, 1, -1, 1, 1, 4, 1'b0, "R9 latched book four");
    send_tuple(8, 0, 12, -12, 0, 0, 2, 1'b0, "R9 latched book two");
    // R10: out of range book values
    send_tuple(13, 13, 16, -3, 0, 0, 2, 1'b0, "R10 book 13");
    send_tuple(15, 15, -16, 16, 0, 0, 2, 1'b0, "R10 book 15");
    drain();
    check(range_err == 1'b0, "R7 no flag without overflow", {31'b0, range_err}, 32'd0);

    // R7: overflow clamps and sticks
    send_tuple(2, 2, 5, 0, -7, 1, 4, 1'b0, "R7 clamped field");
    drain();
    check(range_err == 1'b1, "R7 flag set", {31'b0, range_err}, 32'd1);
    send_tuple(11, 11, -128, 127, 0, 0, 2, 1'b0, "R7 extreme clamp");
    send_tuple(4, 4, 1, 1, 0, 0, 2, 1'b0, "R7 normal after error");
    drain();
    check(range_err == 1'b1, "R7 flag sticky", {31'b0, range_err}, 32'd1);

    // R8: irregular back-pressure across all books
    bp_mode = 1'b1;
    for (int r = 0; r < 60; r++) begin
      int b, mx, v [4];
      b = r % 12;
      mx = mxm(b);
      for (int k = 0; k < 4; k++) v[k] = ((r * 11 + k * 13) % (2 * mx + 1)) - mx;
      send_tuple(b, b, v[0], v[1], v[2], v[3], tsz(b), (r % 5) == 0, "R8 back-pressure");
    end
    drain();
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all fields seen", exp_q.size(), 32'd0);
    check(out_valid == 1'b0, "R9 no extra field", {31'b0, out_valid}, 32'd0);
    report();
  end
endmodule